// File: doc/BRIEF.md
# SD Command Issue and Status Unit

This unit is the command half of a memory-mapped SD host. Software loads a 32-bit argument and a 16-bit command word through a small register port. Setting the new-command flag in the written command word sends exactly one request to the card side over a valid/ready handshake. The request carries the 6-bit command index and the argument. The card side answers in a later cycle with a fail indication, a response length in bytes and up to sixteen response bytes.

The unit checks the returned length against the response type the command asked for. A good response is stored in four 32-bit response registers. A failure sets a fail flag in the command word and a timeout flag in status. Status is write-one-to-clear, and a single registered interrupt line follows the three interrupt bits of status. A busy-wait command that completes while its enable is set in the configuration register raises the busy interrupt.

Top module: `sdcmd_issue_unit`

## Requirements
- R1: After reset, the command, argument, response, status and configuration registers read 0, and both `irq_o` and `card_req_valid` are 0.
- R2: The registers sit at these offsets: command 0x00 (16 bits), argument 0x04, response words 0 to 3 at 0x10, 0x14, 0x18 and 0x1C, status 0x20 (11 bits), configuration 0x38 (11 bits). Read data appears on `bus_rdata` in the cycle after `bus_rd_en`. Any other offset reads 0, and writes to it change nothing.
- R3: A write to the command register with bit 15 set raises `card_req_valid` in the next cycle, with `card_req_index` equal to bits 5:0 of the written word and `card_req_arg` equal to the argument register. The request stays valid until it is accepted with `card_req_ready`. Bit 15 reads back as 1 until the response arrives and as 0 afterwards.
- R4: From the acceptance of a command until its response, writes to the command and argument registers are ignored and no further request is raised.
- R5: When bit 10 (no response) of the command is 0, a response is in error if its length is 0, if its length is 4 while bit 9 (long response) is 1, or if its length is anything other than 4 or 16. An error sets command bit 14 and status bit 6 and leaves the response registers unchanged.
- R6: A response with `card_rsp_fail` high is an error as in R5, whatever the command's response bits are.
- R7: With command bit 10 set, any length is accepted without error and the response registers keep their values.
- R8: A good 4-byte response puts bytes 0,1,2,3 into word 0 with byte 0 as the most significant byte, and clears words 1 to 3. Byte i is carried on `card_rsp_data[127-8i -: 8]`.
- R9: A good 16-byte response fills word 0 from bytes 12..15, word 1 from 8..11, word 2 from 4..7 and word 3 from 0..3, with the lowest byte of each group as the most significant byte.
- R10: A good completion of a command with bit 11 (busy-wait) set sets status bit 10, but only when configuration bit 10 is 1. A failed completion never sets status bit 10.
- R11: A status write clears every bit written as 1. A bit that a completion sets in the same cycle stays set.
- R12: `irq_o` is 1 exactly when any of status bits 10, 9 or 8 is 1, and it changes in the same cycle as status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt line |
| card_req_valid | output | 1 | Command request valid |
| card_req_ready | input | 1 | Card side accepts the request |
| card_req_index | output | 6 | Command index |
| card_req_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Response present (one cycle) |
| card_rsp_fail | input | 1 | Card side failure |
| card_rsp_len | input | 5 | Response length in bytes |
| card_rsp_data | input | 128 | Response bytes, byte 0 in the top byte |

## Verification
A completion can set status bits in the same cycle that software writes a clear mask to status. The bench provokes this by driving a status write in the exact cycle of `card_rsp_valid`. Some clear masks overlap the bits being set and some touch only older bits. The bench then reads status and the interrupt line and compares them with the old value, minus the cleared bits, plus the bits the completion set.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int OFS_CMD  = 'h00;
  localparam int OFS_ARG  = 'h04;
  localparam int OFS_RSP0 = 'h10;
  localparam int OFS_STAT = 'h20;
  localparam int OFS_CFG  = 'h38;

  localparam int CB_NEW   = 15;
  localparam int CB_FAIL  = 14;
  localparam int CB_BUSY  = 11;
  localparam int CB_NORSP = 10;
  localparam int CB_LONG  = 9;
  localparam int CB_IDX_W = 6;

  localparam int SB_TMO   = 6;
  localparam int SB_BSYIR = 10;
  localparam int SB_IRQLO = 8;
  localparam int FB_BSYEN = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} issue_st_t;
endpackage

// File: rtl/sdcmd_rsp_check.sv
module sdcmd_rsp_check #(
  parameter int DW    = 32,
  parameter int NW    = 4,
  parameter int LEN_W = 5
) (
  input  logic                   no_rsp,
  input  logic                   long_req,
  input  logic                   rsp_fail,
  input  logic [LEN_W-1:0]       rsp_len,
  input  logic [NW*DW-1:0]       rsp_data,
  output logic                   err,
  output logic                   load,
  output logic [NW-1:0][DW-1:0]  words
);
  localparam int SHORT_B = DW / 8;
  localparam int LONG_B  = NW * DW / 8;

  logic is_short, is_long, len_bad;

  always_comb begin
    is_short = (rsp_len == LEN_W'(SHORT_B));
    is_long  = (rsp_len == LEN_W'(LONG_B));
    len_bad  = !no_rsp && ((rsp_len == '0) || !(is_short || is_long) ||
                           (is_short && long_req));
    err      = rsp_fail || len_bad;
    load     = !err && !no_rsp;
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    if (w == 0) begin : g_first
      assign words[w] = is_short ? rsp_data[NW*DW-1 -: DW] : rsp_data[DW-1:0];
    end else begin : g_rest
      assign words[w] = is_short ? '0 : rsp_data[w*DW +: DW];
    end
  end
endmodule

// File: rtl/sdcmd_issue_fsm.sv
module sdcmd_issue_fsm
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic busy,
  output logic done
);
  issue_st_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start)     st_q <= ST_REQ;
        ST_REQ:  if (req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) st_q <= ST_IDLE;
        default:                st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == ST_REQ);
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_WAIT) && rsp_valid;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid);
  p_one_req_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_valid);
endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status #(
  parameter int SW    = 11,
  parameter int IRQLO = 8,
  parameter int IRQHI = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_en,
  input  logic [SW-1:0] clr_mask,
  input  logic [SW-1:0] set_mask,
  output logic [SW-1:0] status_q,
  output logic          irq_o
);
  logic [SW-1:0] st_next;

  always_comb begin
    st_next = status_q;
    if (clr_en) st_next = st_next & ~clr_mask;
    st_next = st_next | set_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= st_next;
      irq_o    <= |st_next[IRQHI:IRQLO];
    end
  end

  p_w1c_r11: assert property (@(posedge clk) disable iff (rst)
    clr_en && ((clr_mask & set_mask) == '0) |=> (status_q & $past(clr_mask)) == '0);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (set_mask != '0) |=> (status_q & $past(set_mask)) == $past(set_mask));
  p_irq_r12: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|status_q[IRQHI:IRQLO]));
endmodule

// File: rtl/sdcmd_issue_unit.sv
module sdcmd_issue_unit
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int NW     = 4,
  parameter int LEN_W  = 5,
  parameter int CMD_W  = 16,
  parameter int STAT_W = 11,
  parameter int CFG_W  = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr_en,
  input  logic                  bus_rd_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  irq_o,
  output logic                  card_req_valid,
  input  logic                  card_req_ready,
  output logic [CB_IDX_W-1:0]   card_req_index,
  output logic [DW-1:0]         card_req_arg,
  input  logic                  card_rsp_valid,
  input  logic                  card_rsp_fail,
  input  logic [LEN_W-1:0]      card_rsp_len,
  input  logic [NW*DW-1:0]      card_rsp_data
);
  logic [CMD_W-1:0]       cmd_q;
  logic [DW-1:0]          arg_q;
  logic [CFG_W-1:0]       cfg_q;
  logic [NW-1:0][DW-1:0]  rsp_q;
  logic [NW-1:0][DW-1:0]  rsp_words;
  logic [STAT_W-1:0]      status_q;
  logic [STAT_W-1:0]      set_mask;
  logic [DW-1:0]          rd_mux;
  logic wr_cmd, wr_arg, wr_cfg, wr_stat, start, busy, done, rsp_err, rsp_load;

  assign wr_cmd  = bus_wr_en && (bus_addr == ADDR_W'(OFS_CMD));
  assign wr_arg  = bus_wr_en && (bus_addr == ADDR_W'(OFS_ARG));
  assign wr_cfg  = bus_wr_en && (bus_addr == ADDR_W'(OFS_CFG));
  assign wr_stat = bus_wr_en && (bus_addr == ADDR_W'(OFS_STAT));
  assign start   = wr_cmd && !busy && bus_wdata[CB_NEW];

  sdcmd_issue_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_ready (card_req_ready),
    .rsp_valid (card_rsp_valid),
    .req_valid (card_req_valid),
    .busy      (busy),
    .done      (done)
  );

  sdcmd_rsp_check #(.DW(DW), .NW(NW), .LEN_W(LEN_W)) u_chk (
    .no_rsp   (cmd_q[CB_NORSP]),
    .long_req (cmd_q[CB_LONG]),
    .rsp_fail (card_rsp_fail),
    .rsp_len  (card_rsp_len),
    .rsp_data (card_rsp_data),
    .err      (rsp_err),
    .load     (rsp_load),
    .words    (rsp_words)
  );

  always_comb begin
    set_mask = '0;
    if (done && rsp_err) set_mask[SB_TMO] = 1'b1;
    if (done && !rsp_err && cmd_q[CB_BUSY] && cfg_q[FB_BSYEN]) set_mask[SB_BSYIR] = 1'b1;
  end

  sdcmd_status #(.SW(STAT_W), .IRQLO(SB_IRQLO), .IRQHI(SB_BSYIR)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (wr_stat),
    .clr_mask (bus_wdata[STAT_W-1:0]),
    .set_mask (set_mask),
    .status_q (status_q),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      arg_q <= '0;
      cfg_q <= '0;
      rsp_q <= '0;
    end else begin
      if (wr_cmd && !busy) begin
        cmd_q <= bus_wdata[CMD_W-1:0];
      end else if (done) begin
        cmd_q[CB_NEW] <= 1'b0;
        if (rsp_err) cmd_q[CB_FAIL] <= 1'b1;
      end
      if (wr_arg && !busy) arg_q <= bus_wdata;
      if (wr_cfg) cfg_q <= bus_wdata[CFG_W-1:0];
      if (done && rsp_load) rsp_q <= rsp_words;
    end
  end

  assign card_req_index = cmd_q[CB_IDX_W-1:0];
  assign card_req_arg   = arg_q;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_CMD))  rd_mux = DW'(cmd_q);
    if (bus_addr == ADDR_W'(OFS_ARG))  rd_mux = arg_q;
    if (bus_addr == ADDR_W'(OFS_STAT)) rd_mux = DW'(status_q);
    if (bus_addr == ADDR_W'(OFS_CFG))  rd_mux = DW'(cfg_q);
    for (int i = 0; i < NW; i++) begin
      if (bus_addr == ADDR_W'(OFS_RSP0 + 4 * i)) rd_mux = rsp_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  p_cmd_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    busy && !done && wr_cmd |=> $stable(cmd_q));
  p_arg_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    busy && wr_arg |=> $stable(arg_q));
  p_new_clear_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !cmd_q[CB_NEW]);
  p_fail_flags_r5: assert property (@(posedge clk) disable iff (rst)
    done && rsp_err |=> cmd_q[CB_FAIL] && status_q[SB_TMO]);
  p_rsp_kept_r7: assert property (@(posedge clk) disable iff (rst)
    done && cmd_q[CB_NORSP] |=> $stable(rsp_q));
  p_issue_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> card_req_valid && card_req_index == $past(bus_wdata[CB_IDX_W-1:0]));
endmodule

// File: tb/sdcmd_issue_unit_tb.sv
module sdcmd_issue_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, card_req_valid;
  logic card_req_ready = 1'b0;
  logic [5:0] card_req_index;
  logic [31:0] card_req_arg;
  logic card_rsp_valid = 1'b0, card_rsp_fail = 1'b0;
  logic [4:0] card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;

  always #10 clk = ~clk;

  sdcmd_issue_unit u_dut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .card_req_valid(card_req_valid), .card_req_ready(card_req_ready),
    .card_req_index(card_req_index), .card_req_arg(card_req_arg),
    .card_rsp_valid(card_rsp_valid), .card_rsp_fail(card_rsp_fail),
    .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data)
  );

  int total = 0, bad = 0, cycles = 0;
  logic [15:0] exp_cmd = '0;
  logic [31:0] exp_arg = '0;
  logic [10:0] exp_st  = '0;
  logic [10:0] exp_cfg = '0;
  logic [31:0] exp_rsp [4];
  logic [31:0] rd;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] grab(input logic [127:0] data, input int base);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[31-8*k -: 8] = data[127-8*(base+k) -: 8];
    return w;
  endfunction

  task automatic check_all(input string tag);
    bus_rd(8'h00, rd); check({tag, " R3 cmd"}, rd, {16'h0, exp_cmd});
    for (int i = 0; i < 4; i++) begin
      bus_rd(8'(8'h10 + 4*i), rd); check({tag, " R8/R9 rsp"}, rd, exp_rsp[i]);
    end
    bus_rd(8'h20, rd); check({tag, " R11 status"}, rd, {21'h0, exp_st});
    check({tag, " R12 irq"}, {31'h0, irq_o}, {31'h0, |exp_st[10:8]});
  endtask

  task automatic run_cmd(input string tag, input logic [15:0] cw, input logic [31:0] a,
                         input logic [4:0] len, input logic fail, input logic [127:0] data,
                         input logic coll, input logic [10:0] clr, input int d1, input int d2);
    logic err, nr, lg;
    logic [10:0] sets;
    bus_wr(8'h04, a); exp_arg = a;
    bus_wr(8'h00, {16'h0, cw});
    check({tag, " R3 req_valid"}, {31'h0, card_req_valid}, 32'h1);
    check({tag, " R3 index"}, {26'h0, card_req_index}, {26'h0, cw[5:0]});
    check({tag, " R3 arg"}, card_req_arg, a);
    repeat (d1) @(negedge clk);
    check({tag, " R3 held"}, {31'h0, card_req_valid}, 32'h1);
    card_req_ready = 1'b1;
    @(negedge clk);
    card_req_ready = 1'b0;
    check({tag, " R4 single req"}, {31'h0, card_req_valid}, 32'h0);
    repeat (d2) @(negedge clk);
    card_rsp_valid = 1'b1; card_rsp_fail = fail; card_rsp_len = len; card_rsp_data = data;
    if (coll) begin bus_wr_en = 1'b1; bus_addr = 8'h20; bus_wdata = {21'h0, clr}; end
    @(negedge clk);
    card_rsp_valid = 1'b0; bus_wr_en = 1'b0;
    nr = cw[10]; lg = cw[9];
    err = fail || (!nr && (len == 0 || (len == 4 && lg) || (len != 4 && len != 16)));
    exp_cmd = cw; exp_cmd[15] = 1'b0;
    if (err) exp_cmd[14] = 1'b1;
    if (!err && !nr) begin
      if (len == 4) begin
        exp_rsp[0] = grab(data, 0); exp_rsp[1] = 0; exp_rsp[2] = 0; exp_rsp[3] = 0;
      end else begin
        exp_rsp[0] = grab(data, 12); exp_rsp[1] = grab(data, 8);
        exp_rsp[2] = grab(data, 4);  exp_rsp[3] = grab(data, 0);
      end
    end
    sets = '0;
    if (err) sets[6] = 1'b1;
    if (!err && cw[11] && exp_cfg[10]) sets[10] = 1'b1;
    if (coll) exp_st = exp_st & ~clr;
    exp_st = exp_st | sets;
    check_all(tag);
  endtask

  initial begin
    logic [127:0] pat;
    logic [15:0] cw;
    logic [4:0] ln;
    int sel;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) exp_rsp[i] = '0;
    pat = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 req_valid", {31'h0, card_req_valid}, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    bus_rd(8'h04, rd); check("R1 arg", rd, 32'h0);
    bus_rd(8'h38, rd); check("R1 cfg", rd, 32'h0);
    check_all("R1");
    // R2 map
    bus_wr(8'h04, 32'hDEADBEEF); exp_arg = 32'hDEADBEEF;
    bus_rd(8'h04, rd); check("R2 arg rw", rd, 32'hDEADBEEF);
    bus_wr(8'h38, 32'h0000_0555); exp_cfg = 11'h555;
    bus_rd(8'h38, rd); check("R2 cfg rw", rd, 32'h555);
    bus_wr(8'h44, 32'hFFFF_FFFF);
    bus_rd(8'h44, rd); check("R2 unknown reads 0", rd, 32'h0);
    bus_rd(8'h24, rd); check("R2 unknown reads 0", rd, 32'h0);
    bus_rd(8'h04, rd); check("R2 unknown write ignored", rd, 32'hDEADBEEF);
    check_all("R2");
    // R8 short response
    run_cmd("R8 short", 16'h8011, 32'h0000_1000, 5'd4, 1'b0, pat, 1'b0, '0, 0, 0);
    // R9 long response
    run_cmd("R9 long", 16'h8202, 32'h1, 5'd16, 1'b0, ~pat, 1'b0, '0, 2, 3);
    // R5 length errors
    run_cmd("R5 len0", 16'h8003, 32'h2, 5'd0, 1'b0, pat, 1'b0, '0, 1, 1);
    bus_wr(8'h20, 32'h7FF); exp_st = '0;
    run_cmd("R5 long got short", 16'h8209, 32'h3, 5'd4, 1'b0, pat, 1'b0, '0, 0, 2);
    run_cmd("R5 len7", 16'h8004, 32'h4, 5'd7, 1'b0, pat, 1'b0, '0, 1, 0);
    run_cmd("R9 short asks got 16", 16'h8005, 32'h5, 5'd16, 1'b0, pat ^ 128'h5A, 1'b0, '0, 0, 1);
    // R7 no response
    run_cmd("R7 none len0", 16'h8400, 32'h6, 5'd0, 1'b0, ~pat, 1'b0, '0, 1, 1);
    // R6 card fail
    run_cmd("R6 fail nr", 16'h8400, 32'h7, 5'd0, 1'b1, ~pat, 1'b0, '0, 0, 0);
    run_cmd("R6 fail short", 16'h8001, 32'h8, 5'd4, 1'b1, ~pat, 1'b0, '0, 0, 0);
    bus_wr(8'h20, 32'h7FF); exp_st = '0;
    // R10 busy interrupt
    bus_wr(8'h38, 32'h0); exp_cfg = '0;
    run_cmd("R10 busy disabled", 16'h8C07, 32'h9, 5'd0, 1'b0, pat, 1'b0, '0, 0, 1);
    bus_wr(8'h38, 32'h400); exp_cfg = 11'h400;
    run_cmd("R10 busy enabled", 16'h8C07, 32'hA, 5'd0, 1'b0, pat, 1'b0, '0, 0, 1);
    run_cmd("R10 busy failed", 16'h8807, 32'hB, 5'd0, 1'b0, pat, 1'b0, '0, 0, 0);
    // R11 collision: clear all while set arrives
    run_cmd("R11 collide", 16'h8C08, 32'hC, 5'd0, 1'b0, pat, 1'b1, 11'h7FF, 1, 1);
    run_cmd("R11 collide tmo", 16'h8000, 32'hD, 5'd0, 1'b0, pat, 1'b1, 11'h400, 0, 2);
    // R4 writes ignored while outstanding
    bus_wr(8'h04, 32'h55); exp_arg = 32'h55;
    bus_wr(8'h00, 32'h8005);
    card_req_ready = 1'b1; @(negedge clk); card_req_ready = 1'b0;
    bus_wr(8'h00, 32'h8409);
    check("R4 no second req", {31'h0, card_req_valid}, 32'h0);
    bus_wr(8'h04, 32'h1234);
    bus_rd(8'h00, rd); check("R4 cmd kept busy", rd, 32'h8005);
    bus_rd(8'h04, rd); check("R4 arg kept", rd, 32'h55);
    @(negedge clk);
    card_rsp_valid = 1'b1; card_rsp_len = 5'd4; card_rsp_fail = 1'b0; card_rsp_data = pat;
    @(negedge clk);
    card_rsp_valid = 1'b0;
    exp_cmd = 16'h0005;
    exp_rsp[0] = grab(pat, 0); exp_rsp[1] = 0; exp_rsp[2] = 0; exp_rsp[3] = 0;
    check_all("R4 after");
    // random mix
    for (int n = 0; n < 40; n++) begin
      if (n % 8 == 0) begin
        exp_cfg = 11'($urandom);
        bus_wr(8'h38, {21'h0, exp_cfg});
      end
      cw = 16'($urandom) & 16'h4EFF;
      cw[15] = 1'b1;
      sel = int'($urandom % 4);
      ln = (sel == 0) ? 5'd4 : (sel == 1) ? 5'd16 : (sel == 2) ? 5'd0 : 5'($urandom);
      pat = {$urandom, $urandom, $urandom, $urandom};
      run_cmd("R5/R9 random", cw, $urandom, ln, ($urandom % 5) == 0, pat,
              ($urandom % 3) == 0, 11'($urandom), int'($urandom % 3), int'($urandom % 3));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule